// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits behind the descrambler of a 100 Mb/s twisted-pair receiver. It takes the recovered serial bit stream, one bit per clock in which `bit_en` is high, and turns it into receive nibbles for the media access controller. It watches the raw bits for carrier. It finds the two code-groups that open a stream and locks its symbol boundary to them. It converts each following 5-bit code-group into a 4-bit nibble and stops at the two code-groups that close the stream. A code-group that does not belong inside a frame is reported as a receive error.

Carrier that is never followed by the opening pair is treated as a false carrier. In that case the error output stays high and no data is delivered until the line returns to idle. All outputs change only on a clock edge where `bit_en` is high. The nibble outputs change once per completed code-group, and `rx_crs` can change on any accepted bit.

Top module: `pcs_rx_decoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `rx_nibble` is 0 and `rx_dv`, `rx_crs` and `rx_err` are 0.
- R2: `rx_crs` rises on the accepted bit that makes the 10 most recent accepted bits contain two zeros with at least one bit between them. Two adjacent zeros surrounded by ones do not raise it.
- R3: `rx_crs` falls on the accepted bit that makes the 10 most recent accepted bits all ones.
- R4: The symbol boundary is set where the 10 most recent bits equal 11000 followed by 10001 (the opening pair, first-received bit leftmost). `rx_dv` stays low through the opening pair.
- R5: Each later 5-bit group is taken with its first-received bit as the most significant bit. It is decoded on the bit that completes it, and `rx_dv`=1 is then held for the whole group. The mapping from group to nibble is: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R6: A group of 01101 inside a frame drops `rx_dv` with `rx_err` low. A following group of 00111 ends the frame with `rx_err` low, and `rx_crs` stays high until R3 applies.
- R7: Inside a frame, any group that is neither a data group of R5 nor 01101 sets `rx_err`=1 for that group, keeps `rx_dv`=1 and gives nibble 0. The next valid data group clears `rx_err`.
- R8: If the group after 01101 is not 00111, `rx_err` goes to 1, `rx_dv` stays 0 and the frame ends. `rx_err` clears when carrier falls.
- R9: If carrier rises and the opening pair has not been matched after `HUNT_BITS` (default 10) further accepted bits, `rx_err` goes to 1 on that bit and `rx_dv` stays 0. Both stay that way until carrier falls, and then `rx_err` returns to 0.
- R10: In a clock where `bit_en` is low, `bit_in` is ignored and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | High in clocks that carry a recovered bit |
| bit_in | input | 1 | Recovered, descrambled line bit |
| rx_nibble | output | 4 | Decoded data nibble |
| rx_dv | output | 1 | Nibble holds frame data |
| rx_crs | output | 1 | Carrier sense |
| rx_err | output | 1 | Receive error or false carrier |

## Verification
The checker assumes that every output change is caused by an accepted bit. It also assumes that carrier can rise only on a zero bit and fall only on a one bit, and that data and errors never appear without carrier. The stimulus respects this: it drives `bit_in` and `bit_en` between clock edges, and outside reset it makes every bit change through a single task. Frames are always surrounded by enough ones for carrier to fall, so every scenario starts from an idle window.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;

    localparam int GRP_W = 5;
    localparam int WIN_W = 2 * GRP_W;
    localparam int NIB_W = 4;

    localparam logic [GRP_W-1:0] CG_SOS_A = 5'b11000;
    localparam logic [GRP_W-1:0] CG_SOS_B = 5'b10001;
    localparam logic [GRP_W-1:0] CG_EOS_A = 5'b01101;
    localparam logic [GRP_W-1:0] CG_EOS_B = 5'b00111;
    localparam logic [GRP_W-1:0] CG_IDLE  = 5'b11111;

    typedef enum logic [1:0] {
        CLS_DATA,
        CLS_EOS_A,
        CLS_EOS_B,
        CLS_BAD
    } cg_class_e;

    typedef struct packed {
        cg_class_e        cls;
        logic [NIB_W-1:0] nib;
    } cg_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_DATA,
        ST_TAIL,
        ST_DONE,
        ST_FALSE
    } rx_state_e;

    typedef struct packed {
        logic [NIB_W-1:0] nib;
        logic             dv;
        logic             err;
    } rx_out_t;

    function automatic cg_dec_t decode_cg(input logic [GRP_W-1:0] cg);
        cg_dec_t d;
        d.cls = CLS_DATA;
        d.nib = '0;
        case (cg)
            5'b11110: d.nib = 4'h0;
            5'b01001: d.nib = 4'h1;
            5'b10100: d.nib = 4'h2;
            5'b10101: d.nib = 4'h3;
            5'b01010: d.nib = 4'h4;
            5'b01011: d.nib = 4'h5;
            5'b01110: d.nib = 4'h6;
            5'b01111: d.nib = 4'h7;
            5'b10010: d.nib = 4'h8;
            5'b10011: d.nib = 4'h9;
            5'b10110: d.nib = 4'hA;
            5'b10111: d.nib = 4'hB;
            5'b11010: d.nib = 4'hC;
            5'b11011: d.nib = 4'hD;
            5'b11100: d.nib = 4'hE;
            5'b11101: d.nib = 4'hF;
            CG_EOS_A: d.cls = CLS_EOS_A;
            CG_EOS_B: d.cls = CLS_EOS_B;
            default:  d.cls = CLS_BAD;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pcs_rx_window.sv
module pcs_rx_window
    import pcs_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_next,
    output logic             crs,
    output logic             crs_rise,
    output logic             crs_fall
);

    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] zero_map;
    logic [WIN_W-1:0] row_hit;
    logic             spaced_zeros;
    logic             all_ones;

    assign win_next = bit_en ? {win_q[WIN_W-2:0], bit_in} : win_q;
    assign zero_map = ~win_next;

    // row i: a zero at i and another zero two or more places above it
    for (genvar i = 0; i < WIN_W; i++) begin : g_row
        if (i + 2 < WIN_W) begin : g_pair
            assign row_hit[i] = zero_map[i] & (|(zero_map >> (i + 2)));
        end else begin : g_none
            assign row_hit[i] = 1'b0;
        end
    end

    assign spaced_zeros = |row_hit;
    assign all_ones     = &win_next;
    assign crs_rise     = bit_en & spaced_zeros & ~crs;
    assign crs_fall     = bit_en & all_ones & crs;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '1;
            crs   <= 1'b0;
        end else begin
            win_q <= win_next;
            if (crs_rise) begin
                crs <= 1'b1;
            end else if (crs_fall) begin
                crs <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pcs_rx_symdec.sv
module pcs_rx_symdec
    import pcs_rx_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    output cg_dec_t          dec,
    output logic             sos_hit
);

    assign dec     = decode_cg(win[GRP_W-1:0]);
    assign sos_hit = (win == {CG_SOS_A, CG_SOS_B});

endmodule

// File: rtl/pcs_rx_framer.sv
module pcs_rx_framer
    import pcs_rx_pkg::*;
#(
    parameter int HUNT_BITS = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             crs_rise,
    input  logic             crs_fall,
    input  cg_dec_t          dec,
    input  logic             sos_hit,
    output rx_out_t          out
);

    localparam int HC_W = $clog2(HUNT_BITS + 1);
    localparam int GC_W = $clog2(GRP_W);

    rx_state_e       st_q, st_n;
    logic [GC_W-1:0] grp_q, grp_n;
    logic [HC_W-1:0] hunt_q, hunt_n;
    rx_out_t         out_q, out_n;
    logic            grp_done;

    assign grp_done = bit_en && (grp_q == GC_W'(GRP_W - 1));
    assign out      = out_q;

    always_comb begin
        st_n   = st_q;
        grp_n  = grp_q;
        hunt_n = hunt_q;
        out_n  = out_q;
        if (bit_en) begin
            case (st_q)
                ST_IDLE: begin
                    if (sos_hit) begin
                        st_n  = ST_DATA;
                        grp_n = '0;
                    end else if (crs_rise) begin
                        st_n   = ST_HUNT;
                        hunt_n = '0;
                    end
                end
                ST_HUNT: begin
                    if (sos_hit) begin
                        st_n  = ST_DATA;
                        grp_n = '0;
                    end else if (crs_fall) begin
                        st_n = ST_IDLE;
                    end else if (hunt_q == HC_W'(HUNT_BITS - 1)) begin
                        st_n      = ST_FALSE;
                        out_n.err = 1'b1;
                        out_n.dv  = 1'b0;
                    end else begin
                        hunt_n = hunt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (crs_fall) begin
                        st_n      = ST_IDLE;
                        out_n.dv  = 1'b0;
                        out_n.err = 1'b0;
                    end else if (grp_done) begin
                        grp_n = '0;
                        case (dec.cls)
                            CLS_DATA: begin
                                out_n.nib = dec.nib;
                                out_n.dv  = 1'b1;
                                out_n.err = 1'b0;
                            end
                            CLS_EOS_A: begin
                                st_n      = ST_TAIL;
                                out_n.dv  = 1'b0;
                                out_n.err = 1'b0;
                            end
                            default: begin
                                out_n.nib = '0;
                                out_n.dv  = 1'b1;
                                out_n.err = 1'b1;
                            end
                        endcase
                    end else begin
                        grp_n = grp_q + 1'b1;
                    end
                end
                ST_TAIL: begin
                    if (crs_fall) begin
                        st_n      = ST_IDLE;
                        out_n.err = 1'b0;
                    end else if (grp_done) begin
                        grp_n     = '0;
                        st_n      = ST_DONE;
                        out_n.err = (dec.cls != CLS_EOS_B);
                    end else begin
                        grp_n = grp_q + 1'b1;
                    end
                end
                ST_DONE, ST_FALSE: begin
                    if (crs_fall) begin
                        st_n      = ST_IDLE;
                        out_n.dv  = 1'b0;
                        out_n.err = 1'b0;
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            grp_q  <= '0;
            hunt_q <= '0;
            out_q  <= '0;
        end else begin
            st_q   <= st_n;
            grp_q  <= grp_n;
            hunt_q <= hunt_n;
            out_q  <= out_n;
        end
    end

endmodule

// File: rtl/pcs_rx_decoder.sv
module pcs_rx_decoder
    import pcs_rx_pkg::*;
#(
    parameter int HUNT_BITS = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic [3:0] rx_nibble,
    output logic       rx_dv,
    output logic       rx_crs,
    output logic       rx_err
);

    logic [WIN_W-1:0] win_next;
    logic             crs_rise;
    logic             crs_fall;
    cg_dec_t          dec;
    logic             sos_hit;
    rx_out_t          fr_out;

    pcs_rx_window u_window (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .win_next (win_next),
        .crs      (rx_crs),
        .crs_rise (crs_rise),
        .crs_fall (crs_fall)
    );

    pcs_rx_symdec u_symdec (
        .win     (win_next),
        .dec     (dec),
        .sos_hit (sos_hit)
    );

    pcs_rx_framer #(.HUNT_BITS(HUNT_BITS)) u_framer (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .crs_rise (crs_rise),
        .crs_fall (crs_fall),
        .dec      (dec),
        .sos_hit  (sos_hit),
        .out      (fr_out)
    );

    assign rx_nibble = fr_out.nib;
    assign rx_dv     = fr_out.dv;
    assign rx_err    = fr_out.err;

endmodule

// File: rtl/pcs_rx_decoder_chk.sv
module pcs_rx_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic       bit_in,
    input logic [3:0] rx_nibble,
    input logic       rx_dv,
    input logic       rx_crs,
    input logic       rx_err
);

    // R10
    hold_without_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> $stable({rx_nibble, rx_dv, rx_crs, rx_err}));

    // R2
    crs_rise_on_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_crs) |-> ($past(bit_en) && !$past(bit_in)));

    // R3
    crs_fall_on_one_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_crs) |-> ($past(bit_en) && $past(bit_in)));

    // R5
    dv_needs_crs_chk: assert property (@(posedge clk) disable iff (rst)
        rx_dv |-> rx_crs);

    // R9
    err_needs_crs_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> rx_crs);

endmodule

bind pcs_rx_decoder pcs_rx_decoder_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .rx_nibble (rx_nibble),
    .rx_dv     (rx_dv),
    .rx_crs    (rx_crs),
    .rx_err    (rx_err)
);

// File: tb/pcs_rx_decoder_tb.sv
module pcs_rx_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b1;
    logic [3:0] rx_nibble;
    logic       rx_dv;
    logic       rx_crs;
    logic       rx_err;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    localparam logic [4:0] SYM_J = 5'b11000;
    localparam logic [4:0] SYM_K = 5'b10001;
    localparam logic [4:0] SYM_T = 5'b01101;
    localparam logic [4:0] SYM_R = 5'b00111;
    localparam logic [4:0] SYM_I = 5'b11111;

    always #10 clk = ~clk;

    pcs_rx_decoder dut_i (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .bit_in    (bit_in),
        .rx_nibble (rx_nibble),
        .rx_dv     (rx_dv),
        .rx_crs    (rx_crs),
        .rx_err    (rx_err)
    );

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        bit_in = b;
        bit_en = 1'b1;
        @(posedge clk);
        #1;
        bit_en = 1'b0;
    endtask

    task automatic send_cg(input logic [4:0] cg);
        for (int i = 4; i >= 0; i--) send_bit(cg[i]);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic t_reset();
        check("R1 nibble", rx_nibble, 0);
        check("R1 dv", rx_dv, 0);
        check("R1 crs", rx_crs, 0);
        check("R1 err", rx_err, 0);
    endtask

    task automatic t_adjacent();
        send_ones(12);
        send_bit(1'b0);
        send_bit(1'b0);
        check("R2 adjacent zeros", rx_crs, 0);
        send_ones(12);
        check("R2 adjacent zeros later", rx_crs, 0);
    endtask

    task automatic t_frame();
        send_cg(SYM_I); send_cg(SYM_I);
        for (int i = 4; i >= 1; i--) send_bit(SYM_J[i]);
        check("R2 crs before second zero", rx_crs, 0);
        send_bit(SYM_J[0]);
        check("R2 crs on spaced zero", rx_crs, 1);
        send_cg(SYM_K);
        check("R4 dv low through pair", rx_dv, 0);
        for (int n = 0; n < 16; n++) begin
            if (n == 7) begin
                // R10: stretched group with idle cycles and junk on bit_in
                for (int i = 4; i >= 0; i--) begin
                    bit_in = ~enc(4'(n))[i];
                    repeat (3) @(posedge clk);
                    #1;
                    check("R10 hold nibble", rx_nibble, n - 1);
                    check("R10 hold dv", rx_dv, 1);
                    send_bit(enc(4'(n))[i]);
                end
            end else begin
                send_cg(enc(4'(n)));
            end
            check("R5 nibble", rx_nibble, n);
            check("R5 dv", rx_dv, 1);
            check("R5 err", rx_err, 0);
        end
        send_cg(SYM_T);
        check("R6 dv after end A", rx_dv, 0);
        check("R6 err after end A", rx_err, 0);
        send_cg(SYM_R);
        check("R6 err after end B", rx_err, 0);
        check("R6 crs after end B", rx_crs, 1);
        send_cg(SYM_I);
        send_bit(1'b1);
        check("R3 crs one bit early", rx_crs, 1);
        send_bit(1'b1);
        check("R3 crs falls", rx_crs, 0);
        send_ones(8);
    endtask

    task automatic t_invalid();
        send_cg(SYM_J); send_cg(SYM_K);
        send_cg(enc(4'h5));
        check("R7 data before", rx_nibble, 5);
        send_cg(5'b00100);
        check("R7 err on bad group", rx_err, 1);
        check("R7 dv on bad group", rx_dv, 1);
        check("R7 nibble on bad group", rx_nibble, 0);
        send_cg(enc(4'h9));
        check("R7 err cleared", rx_err, 0);
        check("R7 nibble after", rx_nibble, 9);
        send_cg(SYM_J);
        check("R7 opening code inside frame", rx_err, 1);
        send_cg(SYM_T); send_cg(SYM_R);
        check("R6 clean end", rx_err, 0);
        send_ones(12);
        check("R3 idle after frame", rx_crs, 0);
    endtask

    task automatic t_bad_tail();
        send_cg(SYM_J); send_cg(SYM_K);
        send_cg(enc(4'h3));
        send_cg(SYM_T);
        send_cg(enc(4'h0));
        check("R8 err bad tail", rx_err, 1);
        check("R8 dv bad tail", rx_dv, 0);
        send_cg(enc(4'h6));
        check("R8 frame stays ended", rx_dv, 0);
        send_ones(12);
        check("R8 err cleared by idle", rx_err, 0);
        check("R3 crs idle", rx_crs, 0);
    endtask

    task automatic t_false();
        logic [9:0] tail = 10'b1011011101;
        send_ones(10);
        send_bit(1); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        check("R9 crs up", rx_crs, 1);
        for (int i = 9; i >= 1; i--) send_bit(tail[i]);
        check("R9 no err yet", rx_err, 0);
        send_bit(tail[0]);
        check("R9 err false carrier", rx_err, 1);
        check("R9 dv low", rx_dv, 0);
        send_cg(SYM_J); send_cg(SYM_K); send_cg(enc(4'h2));
        check("R9 no data while false", rx_dv, 0);
        check("R9 err held", rx_err, 1);
        send_ones(12);
        check("R9 err cleared", rx_err, 0);
        check("R9 crs down", rx_crs, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_adjacent();
        t_frame();
        t_invalid();
        t_bad_tail();
        t_false();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule